// File: doc/BRIEF.md
# Two-Phase Three-Level Line Drive Sequencer

This block turns an already-encoded serial biphase stream into the current-source enables for a pseudo-differential line made of two phases, A and B. Each phase has three drive levels: off (no current), low (small current) and high (large current). A phase is driven while the stream is high and transmission is enabled. Each active run starts at the high level for a short pre-emphasis time and then falls to the low level. Phase B repeats the drive pattern of phase A one half-bit later.

The block runs on a clock of `TICKS_PER_BIT` ticks per bit cell, 8 by default. A half-bit is therefore 4 ticks and the pre-emphasis time is 2 ticks. A supply-good input removes every enable at once, so that nothing reaches the shared line while the supply ramps. After a transmission, the block can keep one chosen phase at the low level for a programmed number of half-bits. This quiets ringing on the line. Holding phase A adds one more high-then-low step, while holding phase B adds no extra edge.

Top module: `twx_phase_driver`

## Requirements
- R1: A synchronous active-low reset turns all four enables off on the tick after the reset edge and cancels any hold in progress. The hold does not resume after reset is released.
- R2: While `supply_ok` is 0, all four enables are 0 in the same tick. Internal timing keeps running, so drive resumes mid-pattern when the supply returns.
- R3: A `tx_active`=1, `bp_data`=1 sample turns phase A on at the next tick. A continuous active run shows `a_hi_en` for its first 2 ticks and `a_lo_en` for every tick after that. A run never starts at the low level.
- R4: The high and low enables of one phase are never 1 in the same tick.
- R5: Phase B's enables equal phase A's internal drive delayed by exactly 4 ticks (one half-bit).
- R6: While `tx_active` is 0, `bp_data` is ignored and phase A is off from the next tick. With no hold, phase B turns off once its 4-tick tail has drained.
- R7: A 1-to-0 change of `tx_active` with `hold_len`=N≠0 starts a hold on the next tick that lasts N×4 ticks. `hold_sel` is captured at that point (0 = phase A, 1 = phase B), and later changes of `hold_sel` have no effect on that hold.
- R8: During a hold on phase B, `b_lo_en` is 1 except where B's delayed tail drives high, in which case high wins. Phase A is not touched by a hold on B.
- R9: During a hold on phase A, A is driven high for the first 2 ticks of the hold and low for the rest of it.
- R10: With `hold_len`=0, the end of a transmission starts no hold.
- R11: `tx_active` returning to 1 ends a hold in progress from the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, TICKS_PER_BIT ticks per bit cell |
| rst_n | input | 1 | Synchronous active-low reset |
| bp_data | input | 1 | Encoded biphase level; 1 requests phase A drive |
| tx_active | input | 1 | Transmission enable |
| supply_ok | input | 1 | Supply-good; 0 forces all drive off |
| hold_sel | input | 1 | Phase to hold after transmission: 0 = A, 1 = B |
| hold_len | input | HOLD_W | Hold duration in half-bits; 0 disables the hold |
| a_hi_en | output | 1 | Phase A high-current enable |
| a_lo_en | output | 1 | Phase A low-current enable |
| b_hi_en | output | 1 | Phase B high-current enable |
| b_lo_en | output | 1 | Phase B low-current enable |

## Verification
A wrong run counter in the shaper shows up on phase A within one or two ticks as a missing, early or overlong high level. The same fault appears on phase B exactly four ticks later, so a mismatch between the two phases points to the delay line rather than the shaper. Faults in the hold counter or in the captured phase select appear only after `tx_active` falls. They show as a wrong phase held or as a release that comes one tick or more off N×4, so the longest hold is timed to its last tick and one tick past it.

// File: rtl/twx_pkg.sv
package twx_pkg;
   typedef struct packed {
      logic hi;
      logic lo;
   } drive_t;
endpackage

// File: rtl/twx_pulse_shaper.sv
module twx_pulse_shaper
   import twx_pkg::*;
#(
   parameter int PRE = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   act,
   output drive_t drv
);
   localparam int AW = $clog2(PRE + 1);

   logic [AW-1:0] age_q;
   logic [AW-1:0] age_nxt;

   always_comb begin
      if (!(drv.hi || drv.lo))
         age_nxt = '0;
      else if (age_q != AW'(PRE))
         age_nxt = age_q + 1'b1;
      else
         age_nxt = age_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !act) begin
         age_q  <= '0;
         drv.hi <= 1'b0;
         drv.lo <= 1'b0;
      end else begin
         age_q  <= age_nxt;
         drv.hi <= (age_nxt < AW'(PRE));
         drv.lo <= (age_nxt >= AW'(PRE));
      end
   end

   // R3
   emph_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv.hi || drv.lo) |-> drv.hi);
   // R3
   emph_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv.lo |=> !drv.hi);
endmodule

// File: rtl/twx_half_delay.sv
module twx_half_delay
   import twx_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  drive_t din,
   output drive_t dout
);
   localparam int SW = 2 * DEPTH;

   logic [SW-1:0] sr_q;

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= {sr_q[SW-3:0], din};
         end
      end
   endgenerate

   assign dout = sr_q[SW-1 -: 2];
endmodule

// File: rtl/twx_line_hold.sv
module twx_line_hold #(
   parameter int HALF   = 4,
   parameter int PRE    = 2,
   parameter int HOLD_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_active,
   input  logic              hold_sel,
   input  logic [HOLD_W-1:0] hold_len,
   output logic              hold_on,
   output logic              hold_b,
   output logic              hold_pre
);
   localparam int SH    = $clog2(HALF);
   localparam int REM_W = HOLD_W + SH;
   localparam int AW    = $clog2(PRE + 1);

   logic             tx_q;
   logic [REM_W-1:0] rem_q;
   logic [AW-1:0]    age_q;
   logic             start;

   assign start = tx_q && !tx_active && (hold_len != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q   <= 1'b0;
         rem_q  <= '0;
         age_q  <= '0;
         hold_b <= 1'b0;
      end else begin
         tx_q <= tx_active;
         if (tx_active) begin
            rem_q <= '0;
         end else if (start) begin
            rem_q  <= {hold_len, {SH{1'b0}}};
            age_q  <= '0;
            hold_b <= hold_sel;
         end else if (rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
            if (age_q != AW'(PRE)) age_q <= age_q + 1'b1;
         end
      end
   end

   assign hold_on  = (rem_q != '0);
   assign hold_pre = hold_on && (age_q < AW'(PRE));

   // R11
   hold_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_active |=> !hold_on);
   // R10
   no_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_on && hold_len == '0) |=> !hold_on);
endmodule

// File: rtl/twx_phase_driver.sv
module twx_phase_driver
   import twx_pkg::*;
#(
   parameter int TICKS_PER_BIT = 8,
   parameter int HOLD_W        = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bp_data,
   input  logic              tx_active,
   input  logic              supply_ok,
   input  logic              hold_sel,
   input  logic [HOLD_W-1:0] hold_len,
   output logic              a_hi_en,
   output logic              a_lo_en,
   output logic              b_hi_en,
   output logic              b_lo_en
);
   localparam int HALF = TICKS_PER_BIT / 2;
   localparam int PRE  = HALF / 2;

   initial begin
      assert (TICKS_PER_BIT >= 4 && (TICKS_PER_BIT % 4) == 0)
         else $error("TICKS_PER_BIT must be a multiple of 4");
      assert ((HALF & (HALF - 1)) == 0)
         else $error("half-bit tick count must be a power of two");
      assert (HOLD_W >= 1 && HOLD_W <= 16)
         else $error("HOLD_W out of range");
   end

   drive_t a_drv;
   drive_t b_drv;
   logic   hold_on, hold_b, hold_pre;
   logic   a_hi_raw, a_lo_raw, b_hi_raw, b_lo_raw;

   twx_pulse_shaper #(.PRE(PRE)) u_shape_a (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (tx_active & bp_data),
      .drv   (a_drv)
   );

   twx_half_delay #(.DEPTH(HALF)) u_delay_b (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (a_drv),
      .dout  (b_drv)
   );

   twx_line_hold #(.HALF(HALF), .PRE(PRE), .HOLD_W(HOLD_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_active (tx_active),
      .hold_sel  (hold_sel),
      .hold_len  (hold_len),
      .hold_on   (hold_on),
      .hold_b    (hold_b),
      .hold_pre  (hold_pre)
   );

   always_comb begin
      a_hi_raw = a_drv.hi | (hold_on & ~hold_b & hold_pre);
      a_lo_raw = ~a_hi_raw & (a_drv.lo | (hold_on & ~hold_b & ~hold_pre));
      b_hi_raw = b_drv.hi;
      b_lo_raw = ~b_drv.hi & (b_drv.lo | (hold_on & hold_b));
   end

   assign a_hi_en = a_hi_raw & supply_ok;
   assign a_lo_en = a_lo_raw & supply_ok;
   assign b_hi_en = b_hi_raw & supply_ok;
   assign b_lo_en = b_lo_raw & supply_ok;

   // R1
   reset_off_chk: assert property (@(posedge clk)
      !rst_n |=> !(a_hi_en || a_lo_en || b_hi_en || b_lo_en));
   // R2
   supply_gate_chk: assert property (@(posedge clk)
      !supply_ok |-> !(a_hi_en || a_lo_en || b_hi_en || b_lo_en));
   // R4
   a_excl_chk: assert property (@(posedge clk) !(a_hi_en && a_lo_en));
   // R4
   b_excl_chk: assert property (@(posedge clk) !(b_hi_en && b_lo_en));
   // R6
   idle_a_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_active |=> !(a_drv.hi || a_drv.lo));
   // R8
   hold_b_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_on && hold_b && supply_ok) |-> (b_hi_en || b_lo_en));
endmodule

// File: tb/test_twx_phase_driver.sv
module test_twx_phase_driver;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bp_data = 1'b0;
   logic       tx_active = 1'b0;
   logic       supply_ok = 1'b1;
   logic       hold_sel = 1'b0;
   logic [4:0] hold_len = 5'd0;
   logic       a_hi_en, a_lo_en, b_hi_en, b_lo_en;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   twx_phase_driver #(.TICKS_PER_BIT(8), .HOLD_W(5)) i_twx_phase_driver (
      .clk(clk), .rst_n(rst_n), .bp_data(bp_data), .tx_active(tx_active),
      .supply_ok(supply_ok), .hold_sel(hold_sel), .hold_len(hold_len),
      .a_hi_en(a_hi_en), .a_lo_en(a_lo_en), .b_hi_en(b_hi_en), .b_lo_en(b_lo_en)
   );

   // {tx_active, bp_data, supply_ok, a_hi, a_lo, b_hi, b_lo}
   localparam logic [6:0] VEC [34] = '{
      7'b111_10_00, 7'b111_10_00, 7'b111_01_00, 7'b111_01_00,
      7'b101_00_10, 7'b101_00_10, 7'b101_00_01, 7'b101_00_01,
      7'b111_10_00, 7'b111_10_00, 7'b111_01_00, 7'b111_01_00,
      7'b111_01_10, 7'b111_01_10, 7'b111_01_01, 7'b111_01_01,
      7'b101_00_01, 7'b101_00_01, 7'b101_00_01, 7'b101_00_01,
      7'b011_00_00, 7'b011_00_00, 7'b011_00_00, 7'b011_00_00,
      7'b110_00_00, 7'b110_00_00, 7'b110_00_00, 7'b110_00_00,
      7'b111_01_10, 7'b001_00_10, 7'b001_00_01, 7'b001_00_01,
      7'b001_00_01, 7'b001_00_00
   };

   task automatic cyc(input logic tx, input logic bp, input logic ok);
      @(negedge clk);
      tx_active = tx; bp_data = bp; supply_ok = ok;
      @(posedge clk);
      #2;
   endtask

   task automatic expect4(input string tag, input logic [3:0] exp);
      logic [3:0] got;
      got = {a_hi_en, a_lo_en, b_hi_en, b_lo_en};
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset holds everything off even with active stimulus
      rst_n = 1'b0;
      cyc(1, 1, 1);
      cyc(1, 1, 1);
      expect4("R1 reset state", 4'b0000);
      cyc(0, 0, 1);
      rst_n = 1'b1;
      cyc(0, 0, 1);
      expect4("R1 after release", 4'b0000);

      // R3 R5 R6 R10 R2: table walk, hold_len = 0
      for (int i = 0; i < 34; i++) begin
         cyc(VEC[i][6], VEC[i][5], VEC[i][4]);
         expect4($sformatf("R3 R5 R6 R10 R2 table row %0d", i), VEC[i][3:0]);
      end

      // R7 R8: hold on phase B for 2 half-bits
      hold_sel = 1'b1; hold_len = 5'd2;
      for (int i = 0; i < 4; i++) cyc(1, 1, 1);
      cyc(0, 0, 1); expect4("R8 tail high wins", 4'b0010);
      cyc(0, 0, 1); expect4("R8 tail high wins", 4'b0010);
      cyc(0, 0, 1); expect4("R8 tail low", 4'b0001);
      cyc(0, 0, 1); expect4("R8 tail low", 4'b0001);
      cyc(0, 0, 1); expect4("R8 hold low on B", 4'b0001);
      cyc(0, 0, 1); cyc(0, 0, 1);
      cyc(0, 0, 1); expect4("R7 last hold tick", 4'b0001);
      cyc(0, 0, 1); expect4("R7 hold released", 4'b0000);

      // R9 R7: hold on phase A, select changed mid-hold has no effect
      hold_sel = 1'b0; hold_len = 5'd2;
      for (int i = 0; i < 4; i++) cyc(1, 1, 1);
      cyc(0, 0, 1); expect4("R9 hold A emphasis", 4'b1010);
      hold_sel = 1'b1;
      cyc(0, 0, 1); expect4("R9 hold A emphasis", 4'b1010);
      cyc(0, 0, 1); expect4("R9 hold A low", 4'b0101);
      cyc(0, 0, 1); expect4("R9 hold A low", 4'b0101);
      cyc(0, 0, 1); expect4("R7 select latched, A held", 4'b0100);
      cyc(0, 0, 1); cyc(0, 0, 1);
      cyc(0, 0, 1); expect4("R9 last hold tick", 4'b0100);
      cyc(0, 0, 1); expect4("R9 hold released", 4'b0000);

      // R11: transmit-active return cancels hold
      hold_sel = 1'b1; hold_len = 5'd3;
      cyc(1, 0, 1);
      cyc(0, 0, 1); expect4("R11 hold started", 4'b0001);
      cyc(0, 0, 1);
      hold_len = 5'd0;
      cyc(1, 0, 1); expect4("R11 hold cancelled", 4'b0000);
      cyc(0, 0, 1); expect4("R11 stays off", 4'b0000);

      // R2: supply loss during hold, hold keeps counting
      hold_sel = 1'b1; hold_len = 5'd2;
      cyc(1, 0, 1);
      cyc(0, 0, 1); expect4("R2 hold before supply loss", 4'b0001);
      cyc(0, 0, 0); expect4("R2 supply off gates hold", 4'b0000);
      cyc(0, 0, 1); expect4("R2 hold resumes", 4'b0001);
      for (int i = 0; i < 6; i++) cyc(0, 0, 1);
      expect4("R2 hold expired on time", 4'b0000);

      // R1: reset during hold on A cancels it
      hold_sel = 1'b0; hold_len = 5'd3;
      cyc(1, 0, 1);
      cyc(0, 0, 1); expect4("R1 hold A running", 4'b1000);
      rst_n = 1'b0;
      cyc(0, 0, 1); expect4("R1 reset in hold", 4'b0000);
      rst_n = 1'b1;
      cyc(0, 0, 1); expect4("R1 hold not resumed", 4'b0000);
      cyc(0, 0, 1); expect4("R1 hold not resumed", 4'b0000);

      // R7: longest hold, 31 half-bits = 124 ticks
      hold_sel = 1'b1; hold_len = 5'd31;
      cyc(1, 0, 1);
      cyc(0, 0, 1); expect4("R7 long hold first tick", 4'b0001);
      for (int i = 0; i < 123; i++) cyc(0, 0, 1);
      expect4("R7 long hold tick 124", 4'b0001);
      cyc(0, 0, 1); expect4("R7 long hold released", 4'b0000);

      finish_run();
   end
endmodule